// File: doc/BRIEF.md
# Chip-Select Wait-State Controller

This block sits between a 32-bit embedded CPU bus and the external memory and peripheral regions. It samples the address when a cycle-start pulse arrives, and uses address bits [26:24] to pick one of eight 16 MB chip-select spaces. It then raises one device select and holds it for the length of the cycle. It ends the cycle with a single-clock ready pulse once that region's wait count has elapsed. The expansion region is the one exception to the fixed count: after its minimum wait, the block waits on an external ready line. The boot space goes to one of two ROMs, and a bus-width strap makes that choice.

Several regions are only partly decoded, so their contents repeat inside the 16 MB space. The block shows this through a device offset output, which carries only the address bits that the chosen device decodes. The same map appears again in the upper half of the address range because bit 27 takes no part in decoding.

The sequencing is a four-state machine:

- `ST_IDLE` waits for a start.
- `ST_COUNT` counts down the fixed waits.
- `ST_EXTW` waits for the external ready.
- `ST_DONE` drives ready for one clock.

Its transitions are:

- IDLE→DONE when a zero-wait region starts.
- IDLE→COUNT when a region with waits starts.
- COUNT→COUNT while the count is above one.
- COUNT→DONE when the count ends and no external ready is needed, or when it is already high.
- COUNT→EXTW when the count ends and the external ready is low.
- EXTW→EXTW while the external ready stays low.
- EXTW→DONE when the external ready goes high.
- DONE→IDLE always.

Top module: `cswc_top`

## Requirements
- R1: The space number is `bus_addr[26:23+1]`, that is bits [26:24], with 0 through 7 selecting CS0 through CS7. Bit 27 has no effect on the select, the offset or the wait count.
- R2: `dev_sel` bit positions are: bit 0 DRAM bank 1, bit 1 DRAM bank 2, bit 2 flash, bit 3 expansion, bit 4 I/O, bit 5 SRAM, bit 6 EPROM. At most one bit is high at any time.
- R3: In CS0, `bus_addr[23]`=0 selects bank 1 and `bus_addr[23]`=1 selects bank 2. There are no waits, and `dev_off` is `bus_addr[22:0]`.
- R4: In CS2, flash is selected with 4 waits, and `dev_off` is `bus_addr[22:0]`, so the contents repeat every 8 MB.
- R5: In CS4, the expansion device is selected with 2 waits at minimum, after which the cycle holds until `ext_ready` is high. `dev_off` is `bus_addr[19:0]`.
- R6: In CS5, the I/O device is selected. `bus_addr[20]`=0 gives 1 wait and `bus_addr[20]`=1 gives 7 waits, and `dev_off` is `bus_addr[23:0]`.
- R7: In CS6, SRAM is selected with no waits, and `dev_off` is `bus_addr[18:0]`.
- R8: In CS7, `boot16_strap`=1 selects the EPROM with 5 waits. `boot16_strap`=0 selects the flash with 4 waits. `dev_off` is `bus_addr[23:0]`.
- R9: CS1 and CS3 raise no select and still end with ready after 1 wait. `dev_off` is 0 for them.
- R10: With N waits and the start sampled at edge E0, `cyc_ready` is high for exactly one clock, in the clock after edge E0+N. The select holds from E0 through that ready clock and is 0 outside a cycle.
- R11: A start that arrives while a cycle is running has no effect on the select, the offset or the ready timing.
- R12: While reset is asserted, `cyc_ready` is low and no select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that opens a bus cycle |
| bus_addr | input | ADDR_W | Byte address of the cycle |
| boot16_strap | input | 1 | High selects the 16-bit EPROM as boot ROM |
| ext_ready | input | 1 | Ready from the expansion bus |
| dev_sel | output | 7 | Active-high device selects |
| dev_off | output | 24 | Address bits the selected device decodes |
| cyc_ready | output | 1 | One-clock pulse that ends the cycle |

## Verification
The hardest case to reach from the ports is a second start pulse that lands in the middle of a long count. The bench produces it by opening a slow I/O cycle with 7 waits and pulsing a start with a flash address two clocks later. It then checks that the select, the offset and the ready position all still follow the first cycle. The expansion hold is reached by two different routes: raising `ext_ready` several clocks after the minimum wait, and holding it high from the start so the minimum alone decides the timing.

// File: rtl/cswc_pkg.sv
package cswc_pkg;

    typedef enum logic [2:0] {
        RG_DRAM  = 3'd0,
        RG_NONE1 = 3'd1,
        RG_FLASH = 3'd2,
        RG_NONE3 = 3'd3,
        RG_EXP   = 3'd4,
        RG_IO    = 3'd5,
        RG_SRAM  = 3'd6,
        RG_BOOT  = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_EXTW,
        ST_DONE
    } state_e;

    localparam int SEL_W   = 7;
    localparam int OFF_W   = 24;
    localparam int SEL_BK1 = 0;
    localparam int SEL_BK2 = 1;
    localparam int SEL_FL  = 2;
    localparam int SEL_EXP = 3;
    localparam int SEL_IO  = 4;
    localparam int SEL_SR  = 5;
    localparam int SEL_EP  = 6;

endpackage

// File: rtl/cswc_decode.sv
module cswc_decode
    import cswc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 4,
    parameter int W_FLASH   = 4,
    parameter int W_EXP_MIN = 2,
    parameter int W_IO_FAST = 1,
    parameter int W_IO_SLOW = 7,
    parameter int W_EPROM   = 5,
    parameter int W_UNUSED  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot16,
    output logic [SEL_W-1:0]  sel,
    output logic [OFF_W-1:0]  off,
    output logic [CNT_W-1:0]  waits,
    output logic              ext_mode
);

    localparam int BANK_BIT  = 23;
    localparam int IO_SPD_BT = 20;
    localparam int FL_OFF_W  = 23;
    localparam int EXP_OFF_W = 20;
    localparam int SR_OFF_W  = 19;

    region_e region;

    assign region = region_e'(addr[26:24]);

    always_comb begin
        sel      = '0;
        off      = '0;
        waits    = '0;
        ext_mode = 1'b0;
        unique case (region)
            RG_DRAM: begin
                if (addr[BANK_BIT]) sel[SEL_BK2] = 1'b1;
                else                sel[SEL_BK1] = 1'b1;
                off[FL_OFF_W-1:0] = addr[FL_OFF_W-1:0];
            end
            RG_FLASH: begin
                sel[SEL_FL]       = 1'b1;
                off[FL_OFF_W-1:0] = addr[FL_OFF_W-1:0];
                waits             = CNT_W'(W_FLASH);
            end
            RG_EXP: begin
                sel[SEL_EXP]       = 1'b1;
                off[EXP_OFF_W-1:0] = addr[EXP_OFF_W-1:0];
                waits              = CNT_W'(W_EXP_MIN);
                ext_mode           = 1'b1;
            end
            RG_IO: begin
                sel[SEL_IO] = 1'b1;
                off         = addr[OFF_W-1:0];
                waits       = addr[IO_SPD_BT] ? CNT_W'(W_IO_SLOW)
                                              : CNT_W'(W_IO_FAST);
            end
            RG_SRAM: begin
                sel[SEL_SR]       = 1'b1;
                off[SR_OFF_W-1:0] = addr[SR_OFF_W-1:0];
            end
            RG_BOOT: begin
                off = addr[OFF_W-1:0];
                if (boot16) begin
                    sel[SEL_EP] = 1'b1;
                    waits       = CNT_W'(W_EPROM);
                end else begin
                    sel[SEL_FL] = 1'b1;
                    waits       = CNT_W'(W_FLASH);
                end
            end
            RG_NONE1, RG_NONE3: begin
                waits = CNT_W'(W_UNUSED);
            end
            default: begin
                waits = CNT_W'(W_UNUSED);
            end
        endcase
    end

endmodule

// File: rtl/cswc_fsm.sv
module cswc_fsm
    import cswc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] waits,
    input  logic             ext_mode,
    input  logic             ext_ready,
    output logic             accept,
    output logic             busy,
    output logic             ready
);

    state_e           state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             ext_q, ext_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ext_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            ext_q <= ext_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        ext_nx   = ext_q;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ext_nx = ext_mode;
                    if (waits == '0) begin
                        state_nx = ST_DONE;
                        cnt_nx   = '0;
                    end else begin
                        state_nx = ST_COUNT;
                        cnt_nx   = waits;
                    end
                end
            end
            ST_COUNT: begin
                if (cnt == CNT_W'(1)) begin
                    cnt_nx = '0;
                    if (ext_q && !ext_ready) state_nx = ST_EXTW;
                    else                     state_nx = ST_DONE;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_EXTW: begin
                if (ext_ready) state_nx = ST_DONE;
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
                ext_nx   = 1'b0;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = (state == ST_IDLE) && start;
        busy   = (state != ST_IDLE);
        ready  = (state == ST_DONE);
    end

endmodule

// File: rtl/cswc_top.sv
module cswc_top
    import cswc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 4,
    parameter int W_FLASH   = 4,
    parameter int W_EXP_MIN = 2,
    parameter int W_IO_FAST = 1,
    parameter int W_IO_SLOW = 7,
    parameter int W_EPROM   = 5,
    parameter int W_UNUSED  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              boot16_strap,
    input  logic              ext_ready,
    output logic [6:0]        dev_sel,
    output logic [23:0]       dev_off,
    output logic              cyc_ready
);

    logic [SEL_W-1:0] dec_sel, sel_q;
    logic [OFF_W-1:0] dec_off, off_q;
    logic [CNT_W-1:0] dec_waits;
    logic             dec_ext;
    logic             accept, busy;

    cswc_decode #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .W_FLASH  (W_FLASH),
        .W_EXP_MIN(W_EXP_MIN),
        .W_IO_FAST(W_IO_FAST),
        .W_IO_SLOW(W_IO_SLOW),
        .W_EPROM  (W_EPROM),
        .W_UNUSED (W_UNUSED)
    ) u_decode (
        .addr    (bus_addr),
        .boot16  (boot16_strap),
        .sel     (dec_sel),
        .off     (dec_off),
        .waits   (dec_waits),
        .ext_mode(dec_ext)
    );

    cswc_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .waits    (dec_waits),
        .ext_mode (dec_ext),
        .ext_ready(ext_ready),
        .accept   (accept),
        .busy     (busy),
        .ready    (cyc_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            off_q <= '0;
        end else if (accept) begin
            sel_q <= dec_sel;
            off_q <= dec_off;
        end
    end

    always_comb begin
        dev_sel = busy ? sel_q : '0;
        dev_off = off_q;
    end

endmodule

// File: rtl/cswc_chk.sv
module cswc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_start,
    input logic        ext_ready,
    input logic [6:0]  dev_sel,
    input logic [23:0] dev_off,
    input logic        cyc_ready
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel)); // R2

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ready |=> !cyc_ready); // R10

    AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ready |=> (dev_sel == 7'd0)); // R10

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel[3] && !ext_ready && !cyc_ready) |=> !cyc_ready); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && dev_sel != 7'd0) |=> $stable(dev_off)); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!cyc_ready && dev_sel == 7'd0)); // R12

endmodule

bind cswc_top cswc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .ext_ready(ext_ready),
    .dev_sel  (dev_sel),
    .dev_off  (dev_off),
    .cyc_ready(cyc_ready)
);

// File: tb/cswc_top_bench.sv
module cswc_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        boot16_strap = 1'b0;
    logic        ext_ready = 1'b0;
    logic [6:0]  dev_sel;
    logic [23:0] dev_off;
    logic        cyc_ready;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cswc_top u_cswc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .bus_addr    (bus_addr),
        .boot16_strap(boot16_strap),
        .ext_ready   (ext_ready),
        .dev_sel     (dev_sel),
        .dev_off     (dev_off),
        .cyc_ready   (cyc_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one cycle, returns the sample index of ready (1 = first clock after start).
    // ext_at: -1 holds ext_ready high from the start, otherwise raised after sample ext_at.
    task automatic run_access(input logic [31:0] a, input logic strap, input int ext_at,
                              input int exp_rdy, input logic [6:0] exp_sel,
                              input logic [23:0] exp_off, input string req);
        int first = 0;
        int cnt = 0;
        @(negedge clk);
        bus_addr     = a;
        boot16_strap = strap;
        ext_ready    = (ext_at < 0);
        cyc_start    = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            if (i == 1) begin
                chk(dev_sel == exp_sel, {req, " select"}, dev_sel, exp_sel);
                chk(dev_off == exp_off, {req, " offset"}, dev_off, exp_off);
            end
            if (cyc_ready) begin
                cnt++;
                if (first == 0) first = i;
            end
            if (first != 0 && i == first + 1)
                chk(dev_sel == 7'd0, {req, " R10 select after ready"}, dev_sel, 0);
            if (i == ext_at) ext_ready = 1'b1;
            @(negedge clk);
        end
        ext_ready = 1'b0;
        chk(first == exp_rdy, {req, " ready position"}, first, exp_rdy);
        chk(cnt == 1, {req, " R10 ready width"}, cnt, 1);
    endtask

    task automatic t_reset();
        chk(cyc_ready == 1'b0, "R12 ready in reset", cyc_ready, 0);
        chk(dev_sel == 7'd0, "R12 select in reset", dev_sel, 0);
    endtask

    task automatic t_dram();
        run_access(32'h0012_3456, 1'b0, 0, 1, 7'b000_0001, 24'h12_3456, "R3 bank1");
        run_access(32'h00C0_0010, 1'b0, 0, 1, 7'b000_0010, 24'h40_0010, "R3 bank2");
    endtask

    task automatic t_flash();
        run_access(32'h0298_1234, 1'b0, 0, 5, 7'b000_0100, 24'h18_1234, "R4 flash");
        run_access(32'h0A98_1234, 1'b1, 0, 5, 7'b000_0100, 24'h18_1234, "R1 bit27 mirror");
    endtask

    task automatic t_exp();
        run_access(32'h04A5_6789, 1'b0, -1, 3, 7'b000_1000, 24'h05_6789, "R5 ext high");
        run_access(32'h04A5_6789, 1'b0, 5, 6, 7'b000_1000, 24'h05_6789, "R5 ext late");
    endtask

    task automatic t_io();
        run_access(32'h0501_0040, 1'b0, 0, 2, 7'b001_0000, 24'h01_0040, "R6 fast io");
        run_access(32'h0513_0040, 1'b0, 0, 8, 7'b001_0000, 24'h13_0040, "R6 slow io");
    endtask

    task automatic t_sram();
        run_access(32'h06F8_4321, 1'b0, 0, 1, 7'b010_0000, 24'h00_4321, "R7 sram");
    endtask

    task automatic t_boot();
        run_access(32'h07AB_CDEF, 1'b1, 0, 6, 7'b100_0000, 24'hAB_CDEF, "R8 eprom");
        run_access(32'h07AB_CDEF, 1'b0, 0, 5, 7'b000_0100, 24'hAB_CDEF, "R8 boot flash");
    endtask

    task automatic t_unused();
        run_access(32'h0100_0000, 1'b0, 0, 2, 7'b000_0000, 24'h00_0000, "R9 cs1");
        run_access(32'h0300_0004, 1'b1, 0, 2, 7'b000_0000, 24'h00_0000, "R9 cs3");
    endtask

    task automatic t_restart();
        int first = 0;
        int cnt = 0;
        @(negedge clk);
        bus_addr  = 32'h0513_0040;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        for (int i = 1; i <= 14; i++) begin
            if (i == 2) begin
                bus_addr  = 32'h0298_1234;
                cyc_start = 1'b1;
            end else begin
                cyc_start = 1'b0;
            end
            if (i == 4) begin
                chk(dev_sel == 7'b001_0000, "R11 select kept", dev_sel, 7'b001_0000);
                chk(dev_off == 24'h13_0040, "R11 offset kept", dev_off, 24'h13_0040);
            end
            if (cyc_ready) begin
                cnt++;
                if (first == 0) first = i;
            end
            @(negedge clk);
        end
        chk(first == 8, "R11 ready position", first, 8);
        chk(cnt == 1, "R11 single ready", cnt, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_dram();
        t_flash();
        t_exp();
        t_io();
        t_sram();
        t_boot();
        t_unused();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule